// File: doc/BRIEF.md
# Message Interrupt Pending Scanner

This block walks the pending-bit table of one processor's message-signalled interrupts and finds the interrupt with the best priority that is both pending and enabled. The pending table is a byte-packed memory. The block reads it through a synchronous read port with one cycle of latency. A second read port of the same kind returns each interrupt's configuration word, which holds an enable bit and an 8-bit priority.

The processor interface supplies a start pulse together with the best candidate it already holds: an ID, a priority and a group. The block loads that candidate and tests one interrupt ID per cycle against it. When the scan ends, it raises a one-cycle `done` pulse. At that point the outputs give the resulting best candidate and whether any scanned interrupt replaced the one supplied. The whole scan is gated by a control bit that enables the message interrupts. While that bit is clear, the tables hold no meaningful content, so the block does not read them.

Top module: `lpi_scan`

## Requirements
- R1: If `lpi_en` is low when a start is accepted, the block issues no read on either table port. It pulses `done` in the next cycle with `busy` low, returns `cur_id`/`cur_prio`/`cur_grp` unchanged on the best outputs, and drives `replaced` low.
- R2: A scan covers IDs `LOW_ID` up to but not including 2^(`id_bits`+1), with the limit saturating at 2^`ID_W`. When that range is empty, the block behaves as in R1. Otherwise, for N IDs, `done` pulses N+1 cycles after the edge that accepted the start.
- R3: The pending bit of ID n is bit (n mod 8) of byte (n div 8). The block reads `pend_addr` = n div 8 only for the first ID of the scan and for each ID that is a multiple of 8, so each byte is fetched exactly once.
- R4: The block issues one configuration read per scanned ID, at `cfg_addr` = n − `LOW_ID`. In the returned word, `cfg_rdata[8]` is the enable bit and `cfg_rdata[7:0]` is the priority.
- R5: An ID qualifies only if its pending bit is 1, its enable bit is 1, and `g1ns_en` (sampled at start) is 1.
- R6: A qualifying ID replaces the best candidate if its priority is numerically lower, or if the priorities are equal and its ID is lower.
- R7: The block reports each replacing interrupt with group code 2'b10 on `best_grp`.
- R8: At `done`, `replaced` is 1 exactly when at least one ID replaced the best candidate during the scan.
- R9: The block ignores a start pulse while `busy` is high. It samples `lpi_en`, `g1ns_en`, `id_bits` and the incoming candidate only on the edge that accepts a start.
- R10: `busy` is high from the accepting edge until `done`. `done` is a single-cycle pulse. The best outputs hold their value while the block is idle. Reset leaves `busy` and `done` low, `best_prio` at 8'hFF, and `best_id`, `best_grp` and `replaced` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Scan request pulse |
| lpi_en | input | 1 | Message interrupt enable; gates the whole scan |
| g1ns_en | input | 1 | Non-secure group 1 enable |
| id_bits | input | IDB_W | ID width field; the range ends at 2^(id_bits+1) |
| cur_id | input | ID_W | Incoming best candidate ID |
| cur_prio | input | 8 | Incoming best candidate priority |
| cur_grp | input | 2 | Incoming best candidate group |
| pend_rd_en | output | 1 | Pending table read strobe |
| pend_addr | output | ID_W-3 | Pending table byte address |
| pend_rdata | input | 8 | Pending byte, valid one cycle after the strobe |
| cfg_rd_en | output | 1 | Configuration table read strobe |
| cfg_addr | output | ID_W | Configuration entry index |
| cfg_rdata | input | 9 | {enable, priority}, valid one cycle after the strobe |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| best_id | output | ID_W | Resulting best ID |
| best_prio | output | 8 | Resulting best priority |
| best_grp | output | 2 | Resulting best group |
| replaced | output | 1 | Best candidate was replaced during the scan |

## Verification
The assertions check on every cycle that:
- reads happen only while a scan runs, and a disabled start finishes at once;
- each pending byte fetch is aligned with the configuration index of an ID that starts a byte;
- the best priority never rises during a scan;
- a replaced candidate carries the fixed group code;
- `done` is a lone pulse that ends `busy`.

Some outcomes can only be shown by the bench's scenarios, which compare every clock against a behavioural model. These are which ID wins, the tie-break on equal priority, the effect of the group enable, the exact scan length and read counts for small, empty and saturated ranges, and the rejection of a start during a scan.

// File: rtl/lpi_scan_pkg.sv
package lpi_scan_pkg;
    localparam int PRIO_W = 8;
    localparam int GRP_W  = 2;
    localparam int CFG_W  = PRIO_W + 1;
    localparam logic [GRP_W-1:0] GRP_NS1 = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_DRAIN
    } scan_st_e;
endpackage

// File: rtl/lpi_scan_range.sv
module lpi_scan_range #(
    parameter int ID_W   = 16,
    parameter int IDB_W  = 5,
    parameter int LOW_ID = 8192
) (
    input  logic [IDB_W-1:0] id_bits,
    output logic [ID_W:0]    limit,
    output logic             empty
);
    localparam logic [ID_W:0] LOW_EXT = (ID_W+1)'(LOW_ID);

    logic [IDB_W:0] shamt;

    always_comb begin
        shamt = {1'b0, id_bits} + 1'b1;
        if (int'(shamt) >= ID_W) begin
            // saturate at the full ID space
            limit = {1'b1, {ID_W{1'b0}}};
        end else begin
            limit = (ID_W+1)'(1) << shamt;
        end
        empty = (limit <= LOW_EXT);
    end
endmodule

// File: rtl/lpi_scan_issue.sv
module lpi_scan_issue
    import lpi_scan_pkg::*;
#(
    parameter int ID_W   = 16,
    parameter int LOW_ID = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ID_W:0]     limit,
    output logic              busy,
    output logic              pend_rd_en,
    output logic [ID_W-4:0]   pend_addr,
    output logic              cfg_rd_en,
    output logic [ID_W-1:0]   cfg_addr,
    output logic              ev_vld,
    output logic [ID_W-1:0]   ev_id,
    output logic              ev_fresh,
    output logic              ev_last
);
    localparam logic [ID_W-1:0] LOW_V = ID_W'(LOW_ID);

    typedef struct packed {
        scan_st_e        st;
        logic [ID_W-1:0] nid;
        logic [ID_W:0]   lim;
        logic            first;
        logic            ev_vld;
        logic [ID_W-1:0] ev_id;
        logic            ev_fresh;
        logic            ev_last;
    } iss_t;

    iss_t d, q;

    always_comb begin
        d            = q;
        d.ev_vld     = 1'b0;
        d.ev_fresh   = 1'b0;
        d.ev_last    = 1'b0;
        pend_rd_en   = 1'b0;
        pend_addr    = q.nid[ID_W-1:3];
        cfg_rd_en    = 1'b0;
        cfg_addr     = q.nid - LOW_V;
        unique case (q.st)
            ST_IDLE: begin
                if (go) begin
                    d.st    = ST_SCAN;
                    d.nid   = LOW_V;
                    d.lim   = limit;
                    d.first = 1'b1;
                end
            end
            ST_SCAN: begin
                cfg_rd_en  = 1'b1;
                // one byte fetch covers eight consecutive IDs
                pend_rd_en = q.first || (q.nid[2:0] == 3'd0);
                d.ev_vld   = 1'b1;
                d.ev_id    = q.nid;
                d.ev_fresh = pend_rd_en;
                d.first    = 1'b0;
                if (({1'b0, q.nid} + (ID_W+1)'(1)) == q.lim) begin
                    d.st      = ST_DRAIN;
                    d.ev_last = 1'b1;
                end else begin
                    d.nid = q.nid + 1'b1;
                end
            end
            ST_DRAIN: d.st = ST_IDLE;
            default:  d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != ST_IDLE);
    assign ev_vld   = q.ev_vld;
    assign ev_id    = q.ev_id;
    assign ev_fresh = q.ev_fresh;
    assign ev_last  = q.ev_last;
endmodule

// File: rtl/lpi_scan_pick.sv
module lpi_scan_pick
    import lpi_scan_pkg::*;
#(
    parameter int ID_W = 16
) (
    input  logic [ID_W-1:0]   ev_id,
    input  logic [7:0]        pend_byte,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              grp_en,
    input  logic [ID_W-1:0]   best_id,
    input  logic [PRIO_W-1:0] best_prio,
    output logic              take
);
    logic              pend_bit;
    logic              ena;
    logic [PRIO_W-1:0] prio;
    logic              qual;
    logic              wins;

    always_comb begin
        pend_bit = pend_byte[ev_id[2:0]];
        ena      = cfg_word[CFG_W-1];
        prio     = cfg_word[PRIO_W-1:0];
        qual     = pend_bit && ena && grp_en;
        wins     = (prio < best_prio) ||
                   ((prio == best_prio) && (ev_id < best_id));
        take     = qual && wins;
    end
endmodule

// File: rtl/lpi_scan.sv
module lpi_scan
    import lpi_scan_pkg::*;
#(
    parameter int ID_W   = 16,
    parameter int IDB_W  = 5,
    parameter int LOW_ID = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              lpi_en,
    input  logic              g1ns_en,
    input  logic [IDB_W-1:0]  id_bits,
    input  logic [ID_W-1:0]   cur_id,
    input  logic [7:0]        cur_prio,
    input  logic [1:0]        cur_grp,
    output logic              pend_rd_en,
    output logic [ID_W-4:0]   pend_addr,
    input  logic [7:0]        pend_rdata,
    output logic              cfg_rd_en,
    output logic [ID_W-1:0]   cfg_addr,
    input  logic [8:0]        cfg_rdata,
    output logic              busy,
    output logic              done,
    output logic [ID_W-1:0]   best_id,
    output logic [7:0]        best_prio,
    output logic [1:0]        best_grp,
    output logic              replaced
);
    typedef struct packed {
        logic [ID_W-1:0]   bid;
        logic [PRIO_W-1:0] bprio;
        logic [GRP_W-1:0]  bgrp;
        logic              rep;
        logic              done;
        logic [7:0]        pbuf;
        logic              g1;
    } top_t;

    top_t d, q;

    logic [ID_W:0]   limit;
    logic            empty;
    logic            start_ok;
    logic            go;
    logic            ev_vld;
    logic [ID_W-1:0] ev_id;
    logic            ev_fresh;
    logic            ev_last;
    logic [7:0]      pend_byte;
    logic            take;

    lpi_scan_range #(.ID_W(ID_W), .IDB_W(IDB_W), .LOW_ID(LOW_ID)) u_range (
        .id_bits (id_bits),
        .limit   (limit),
        .empty   (empty)
    );

    assign start_ok = start && !busy;
    assign go       = start_ok && lpi_en && !empty;

    lpi_scan_issue #(.ID_W(ID_W), .LOW_ID(LOW_ID)) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .limit      (limit),
        .busy       (busy),
        .pend_rd_en (pend_rd_en),
        .pend_addr  (pend_addr),
        .cfg_rd_en  (cfg_rd_en),
        .cfg_addr   (cfg_addr),
        .ev_vld     (ev_vld),
        .ev_id      (ev_id),
        .ev_fresh   (ev_fresh),
        .ev_last    (ev_last)
    );

    assign pend_byte = ev_fresh ? pend_rdata : q.pbuf;

    lpi_scan_pick #(.ID_W(ID_W)) u_pick (
        .ev_id     (ev_id),
        .pend_byte (pend_byte),
        .cfg_word  (cfg_rdata),
        .grp_en    (q.g1),
        .best_id   (q.bid),
        .best_prio (q.bprio),
        .take      (take)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start_ok) begin
            d.bid   = cur_id;
            d.bprio = cur_prio;
            d.bgrp  = cur_grp;
            d.rep   = 1'b0;
            d.g1    = g1ns_en;
            if (!go) begin
                d.done = 1'b1;
            end
        end
        if (ev_vld) begin
            d.pbuf = pend_byte;
            if (take) begin
                d.bid   = ev_id;
                d.bprio = cfg_rdata[PRIO_W-1:0];
                d.bgrp  = GRP_NS1;
                d.rep   = 1'b1;
            end
            if (ev_last) begin
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.bprio <= '1;
        end else begin
            q <= d;
        end
    end

    assign done      = q.done;
    assign best_id   = q.bid;
    assign best_prio = q.bprio;
    assign best_grp  = q.bgrp;
    assign replaced  = q.rep;
endmodule

// File: rtl/lpi_scan_chk.sv
module lpi_scan_chk #(
    parameter int ID_W   = 16,
    parameter int LOW_ID = 8192
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            lpi_en,
    input logic            busy,
    input logic            done,
    input logic            pend_rd_en,
    input logic [ID_W-4:0] pend_addr,
    input logic            cfg_rd_en,
    input logic [ID_W-1:0] cfg_addr,
    input logic [7:0]      best_prio,
    input logic [1:0]      best_grp,
    input logic            replaced
);
    logic [ID_W-1:0] scan_id;
    assign scan_id = cfg_addr + ID_W'(LOW_ID);

    AST_NO_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pend_rd_en && !cfg_rd_en)); // R1
    AST_OFF_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !lpi_en) |=> (done && !busy)); // R1
    AST_BYTE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        pend_rd_en |-> (cfg_rd_en && pend_addr == scan_id[ID_W-1:3])); // R3
    AST_BYTE_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_en && scan_id[2:0] == 3'd0) |-> pend_rd_en); // R3
    AST_PRIO_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (best_prio <= $past(best_prio))); // R6
    AST_REP_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        replaced |-> (best_grp == 2'b10)); // R7
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !$past(done))); // R10
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R10
endmodule

bind lpi_scan lpi_scan_chk #(.ID_W(ID_W), .LOW_ID(LOW_ID)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .lpi_en     (lpi_en),
    .busy       (busy),
    .done       (done),
    .pend_rd_en (pend_rd_en),
    .pend_addr  (pend_addr),
    .cfg_rd_en  (cfg_rd_en),
    .cfg_addr   (cfg_addr),
    .best_prio  (best_prio),
    .best_grp   (best_grp),
    .replaced   (replaced)
);

// File: tb/tb_lpi_scan.sv
module tb_lpi_scan;
    localparam int ID_W   = 16;
    localparam int IDB_W  = 5;
    localparam int LOW_ID = 8192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, lpi_en = 1'b0, g1ns_en = 1'b0;
    logic [IDB_W-1:0] id_bits = '0;
    logic [ID_W-1:0] cur_id = '0;
    logic [7:0] cur_prio = '0;
    logic [1:0] cur_grp = '0;
    logic pend_rd_en, cfg_rd_en, busy, done, replaced;
    logic [ID_W-4:0] pend_addr;
    logic [ID_W-1:0] cfg_addr, best_id;
    logic [7:0] pend_rdata = '0, best_prio;
    logic [8:0] cfg_rdata = '0;
    logic [1:0] best_grp;

    always #4 clk = ~clk;

    lpi_scan dut (
        .clk(clk), .rst_n(rst_n), .start(start), .lpi_en(lpi_en), .g1ns_en(g1ns_en),
        .id_bits(id_bits), .cur_id(cur_id), .cur_prio(cur_prio), .cur_grp(cur_grp),
        .pend_rd_en(pend_rd_en), .pend_addr(pend_addr), .pend_rdata(pend_rdata),
        .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
        .busy(busy), .done(done), .best_id(best_id), .best_prio(best_prio),
        .best_grp(best_grp), .replaced(replaced)
    );

    int seed = 0, mode = 0;
    int n_cmp = 0, n_bad = 0;
    string cur_req = "R10";

    function automatic bit pbit(int n);
        return ((n * 37 + seed) % 11) < 3;
    endfunction
    function automatic logic [7:0] pbyte(int a);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) r[b] = pbit(a * 8 + b);
        return r;
    endfunction
    function automatic bit cen(int n);
        return ((n * 13 + seed) % 5) != 0;
    endfunction
    function automatic int cpri(int n);
        return (mode == 1) ? 32'h40 : ((n * 131 + seed * 7) % 256);
    endfunction

    // table memories with one cycle read latency
    always @(posedge clk) begin
        if (pend_rd_en) pend_rdata <= pbyte(int'(pend_addr));
        if (cfg_rd_en) cfg_rdata <= {cen(int'(cfg_addr) + LOW_ID), 8'(cpri(int'(cfg_addr) + LOW_ID))};
    end

    // behavioural reference model
    int  e_rem = 0, e_nb = 0, e_nc = 0, got_nb = 0, got_nc = 0;
    bit  e_busy = 0, e_done = 0, e_rep = 0, p_rep = 0;
    int  e_id = 0, e_prio = 255, e_grp = 0, p_id = 0, p_prio = 0, p_grp = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            e_rem = 0; e_busy = 0; e_done = 0; e_rep = 0;
            e_id = 0; e_prio = 255; e_grp = 0;
        end else begin
            e_done = 0;
            if (e_rem > 0) begin
                e_rem--;
                if (e_rem == 0) begin
                    e_busy = 0; e_done = 1;
                    e_id = p_id; e_prio = p_prio; e_grp = p_grp; e_rep = p_rep;
                end
            end else if (start) begin
                int lim, cnt;
                lim = (int'(id_bits) + 1 >= ID_W) ? (1 << ID_W) : (1 << (int'(id_bits) + 1));
                cnt = (lim > LOW_ID) ? lim - LOW_ID : 0;
                p_id = int'(cur_id); p_prio = int'(cur_prio); p_grp = int'(cur_grp); p_rep = 0;
                got_nb = 0; got_nc = 0;
                if (!lpi_en || cnt == 0) begin
                    e_done = 1; e_nb = 0; e_nc = 0;
                    e_id = p_id; e_prio = p_prio; e_grp = p_grp; e_rep = 0;
                end else begin
                    for (int n = LOW_ID; n < lim; n++) begin
                        if (pbit(n) && cen(n) && g1ns_en &&
                            (cpri(n) < p_prio || (cpri(n) == p_prio && n < p_id))) begin
                            p_id = n; p_prio = cpri(n); p_grp = 2; p_rep = 1;
                        end
                    end
                    e_busy = 1; e_rem = cnt + 1; e_nb = cnt / 8; e_nc = cnt;
                end
            end
        end
    end

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend_rd_en) got_nb++;
            if (cfg_rd_en) got_nc++;
            chk(busy == e_busy, "R10", "busy", busy, e_busy);
            chk(done == e_done, "R10", "done", done, e_done);
            if (!e_busy) begin
                chk(!pend_rd_en && !cfg_rd_en, "R1", "idle read", pend_rd_en | cfg_rd_en, 0);
                chk(int'(best_id) == e_id, cur_req, "best_id", best_id, e_id);
                chk(int'(best_prio) == e_prio, cur_req, "best_prio", best_prio, e_prio);
                chk(int'(best_grp) == e_grp, "R7", "best_grp", best_grp, e_grp);
                chk(replaced == e_rep, "R8", "replaced", replaced, e_rep);
            end
            if (e_done) begin
                chk(got_nb == e_nb, "R3", "pending byte reads", got_nb, e_nb);
                chk(got_nc == e_nc, "R4", "config reads", got_nc, e_nc);
            end
        end
    end

    task automatic scan(string req, bit en, bit g1, int ib, int id, int pr, int gr);
        cur_req = req;
        @(negedge clk);
        lpi_en = en; g1ns_en = g1; id_bits = IDB_W'(ib);
        cur_id = ID_W'(id); cur_prio = 8'(pr); cur_grp = 2'(gr);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (e_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    bit finished = 0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        cur_req = "R10";
        chk(best_prio == 8'hFF && !busy && !done, "R10", "reset state", best_prio, 255);
        seed = 3; mode = 0;
        scan("R1", 0, 1, 13, 100, 128, 1);
        scan("R2", 1, 1, 12, 200, 128, 1);
        scan("R6", 1, 1, 13, 16'h1234, 255, 0);
        seed = 7;
        scan("R5", 1, 0, 13, 500, 255, 1);
        mode = 1;
        scan("R6", 1, 1, 13, 9000, 64, 0);
        mode = 0; seed = 11;
        scan("R6", 1, 1, 13, 0, 0, 3);
        // a second start during the scan must be ignored
        cur_req = "R9";
        @(negedge clk);
        lpi_en = 1; g1ns_en = 1; id_bits = 13; cur_id = 16'hFFFF; cur_prio = 8'hFF; cur_grp = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        repeat (100) @(negedge clk);
        lpi_en = 0; cur_id = 5; cur_prio = 0; start = 1;
        @(negedge clk);
        start = 0;
        while (e_busy) @(negedge clk);
        repeat (3) @(negedge clk);
        seed = 2;
        scan("R2", 1, 1, 14, 40000, 200, 1);
        scan("R2", 1, 1, 15, 65535, 255, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule